// File: doc/BRIEF.md
# Code-Density Histogram INL Estimator

This block measures the integral nonlinearity of a converter under test from the output codes it produces while a slow ramp drives its input. In the capture phase each valid code word adds one to the counter of its bin. When the capture is closed, the block walks the bins and forms each estimated transition level as a running total of the bin counts below it. It then rates every code against the straight line through the first and the last transition, and streams one signed fixed-point INL figure per code, in rising code order.

A run starts with a `start` pulse, which clears every bin and every flag. Codes are then fed with `code_valid`, and `capture_end` closes the capture. Results appear as single-cycle `inl_valid` pulses. `done` rises after the last result, or at once if the histogram cannot define a fit line. When `done` is high, the largest INL magnitude and the code where it occurs are stable on their outputs. The code width, the counter width and the number of fraction bits are parameters. The default is a 4-bit converter (N = 16 codes) with 12-bit bins and 8 fraction bits.

Top module: `inl_estimator`

## Requirements
- R1: After reset, `inl_valid`, `done`, `err_flag`, `sat_flag` and `max_abs_inl` are 0 and no result is produced until a run is started.
- R2: A `start` pulse clears all bins, `err_flag`, `sat_flag` and the maximum tracker, and enters capture. During capture a code is counted only in cycles where `code_valid` is 1. Code values seen while `code_valid` is 0 have no effect on the results.
- R3: A bin counter holds at 2^CNT_W−1 (4095 by default) instead of wrapping. Counting a code whose bin is already full sets `sat_flag`, which stays set until the next `start`.
- R4: The estimated transition level of code k is T_k = H_0 + … + H_(k−1), the sum of the counts of all codes below k.
- R5: For k = 1 … N−1 the result is INL_k = floor((T_k − T_1)·(N−2)·2^FRAC_W / (T_(N−1) − T_1)) − (k−1)·2^FRAC_W. It is given as a two's-complement value of CODE_W+FRAC_W+1 bits, in units of 2^−FRAC_W LSB.
- R6: Results come out with `inl_code` = 1, 2, …, N−1 in that order, one `inl_valid` pulse per code, and none after `done`.
- R7: The results for code 1 and for code N−1 are exactly 0.
- R8: If T_(N−1) equals T_1, no result is produced, and `err_flag` and `done` are both set.
- R9: While `done` is high after a good run, `max_abs_inl` is the largest |INL_k| and `max_code` is the lowest code that reaches it. If every INL_k is 0, `max_code` is 1.
- R10: `done` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear all bins and flags and begin capture |
| code_valid | input | 1 | Qualifies `code` in the current cycle |
| code | input | CODE_W | Output code of the converter under test |
| capture_end | input | 1 | Close capture and begin evaluation |
| inl_valid | output | 1 | One-cycle strobe for each result |
| inl_code | output | CODE_W | Code index of the current result |
| inl_value | output | CODE_W+FRAC_W+1 | Signed INL of that code, FRAC_W fraction bits |
| done | output | 1 | Evaluation finished (or aborted) |
| err_flag | output | 1 | Fit line undefined, evaluation aborted |
| sat_flag | output | 1 | At least one bin reached its ceiling |
| max_abs_inl | output | CODE_W+FRAC_W+1 | Largest INL magnitude of the run |
| max_code | output | CODE_W | Code at which that magnitude first occurs |

## Verification
The hardest states to reach from the ports are the full bin and the empty span. A bin only saturates after more than four thousand hits on one code. The stimulus reaches it with a long burst on a single code, and then checks that the results follow the held count of 4095 and not a wrapped one. The undefined fit line needs every code from 1 to N−2 to be missing. The stimulus produces it with a histogram that has hits only on the lowest and highest codes. A restart in the middle of result streaming checks that old state does not leak into the next run.

// File: rtl/inl_pkg.sv
package inl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_SUM,
        ST_CHECK,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_DONE,
        ST_FAULT
    } inl_state_t;
endpackage

// File: rtl/inl_hist_bins.sv
module inl_hist_bins #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_idx,
    input  logic [CODE_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              sat_hit
);
    localparam int NBINS = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bin_w [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (clear)
                cnt_q <= '0;
            else if (inc_en && inc_idx == CODE_W'(g) && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
        assign bin_w[g] = cnt_q;
    end

    assign rd_cnt  = bin_w[rd_idx];
    assign sat_hit = inc_en && (bin_w[inc_idx] == CNT_MAX);
endmodule

// File: rtl/inl_seq_div.sv
module inl_seq_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 16,
    parameter int QUO_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             fin,
    output logic [QUO_W-1:0] quotient
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] dq_q;
    logic [CW-1:0]    left_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, dq_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, divisor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dq_q   <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (abort) begin
                run_q <= 1'b0;
            end else if (go) begin
                rem_q  <= '0;
                dq_q   <= dividend;
                left_q <= CW'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? DEN_W'(trial - {1'b0, divisor}) : trial[DEN_W-1:0];
                dq_q   <= {dq_q[NUM_W-2:0], fits};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quotient = dq_q[QUO_W-1:0];
endmodule

// File: rtl/inl_estimator.sv
module inl_estimator
    import inl_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             code_valid,
    input  logic [CODE_W-1:0]                code,
    input  logic                             capture_end,
    output logic                             inl_valid,
    output logic [CODE_W-1:0]                inl_code,
    output logic signed [CODE_W+FRAC_W:0]    inl_value,
    output logic                             done,
    output logic                             err_flag,
    output logic                             sat_flag,
    output logic [CODE_W+FRAC_W:0]           max_abs_inl,
    output logic [CODE_W-1:0]                max_code
);
    localparam int NBINS = 1 << CODE_W;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam int NUM_W = SUM_W + CODE_W + FRAC_W;
    localparam int OUT_W = CODE_W + FRAC_W + 1;
    localparam logic [CODE_W-1:0] LAST_SUM  = CODE_W'(NBINS - 2);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NBINS - 1);

    inl_state_t state, nstate;

    logic [CODE_W-1:0] idx_q;
    logic [SUM_W-1:0]  total_q, t1_q, run_q;
    logic [CNT_W-1:0]  rd_cnt;
    logic              sat_hit;
    logic              div_fin;
    logic [OUT_W-1:0]  quot;
    logic [SUM_W-1:0]  span, rise;
    logic [NUM_W-1:0]  dividend;
    logic [OUT_W-1:0]  kofs;
    logic signed [OUT_W-1:0] new_inl;
    logic [OUT_W-1:0]  new_abs;

    inl_hist_bins #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .inc_en  (state == ST_CAPTURE && code_valid),
        .inc_idx (code),
        .rd_idx  (idx_q),
        .rd_cnt  (rd_cnt),
        .sat_hit (sat_hit)
    );

    assign span     = total_q - t1_q;
    assign rise     = run_q - t1_q;
    assign dividend = (NUM_W'(rise) * NUM_W'(NBINS - 2)) << FRAC_W;

    inl_seq_div #(.NUM_W(NUM_W), .DEN_W(SUM_W), .QUO_W(OUT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (start),
        .go       (state == ST_DIV_GO),
        .dividend (dividend),
        .divisor  (span),
        .fin      (div_fin),
        .quotient (quot)
    );

    assign kofs    = OUT_W'(idx_q - 1'b1) << FRAC_W;
    assign new_inl = $signed(quot) - $signed(kofs);
    assign new_abs = new_inl[OUT_W-1] ? OUT_W'(-new_inl) : OUT_W'(new_inl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        if (start) begin
            nstate = ST_CAPTURE;
        end else begin
            unique case (state)
                ST_IDLE:     nstate = ST_IDLE;
                ST_CAPTURE:  if (capture_end) nstate = ST_SUM;
                ST_SUM:      if (idx_q == LAST_SUM) nstate = ST_CHECK;
                ST_CHECK:    nstate = (total_q == t1_q) ? ST_FAULT : ST_DIV_GO;
                ST_DIV_GO:   nstate = ST_DIV_WAIT;
                ST_DIV_WAIT: if (div_fin) nstate = (idx_q == LAST_CODE) ? ST_DONE : ST_DIV_GO;
                ST_DONE:     nstate = ST_DONE;
                ST_FAULT:    nstate = ST_FAULT;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            total_q     <= '0;
            t1_q        <= '0;
            run_q       <= '0;
            inl_valid   <= 1'b0;
            inl_code    <= '0;
            inl_value   <= '0;
            err_flag    <= 1'b0;
            sat_flag    <= 1'b0;
            max_abs_inl <= '0;
            max_code    <= CODE_W'(1);
        end else begin
            inl_valid <= 1'b0;
            if (start) begin
                idx_q       <= '0;
                total_q     <= '0;
                t1_q        <= '0;
                run_q       <= '0;
                err_flag    <= 1'b0;
                sat_flag    <= 1'b0;
                max_abs_inl <= '0;
                max_code    <= CODE_W'(1);
            end else begin
                unique case (state)
                    ST_CAPTURE: begin
                        if (sat_hit) sat_flag <= 1'b1;
                    end
                    ST_SUM: begin
                        total_q <= total_q + SUM_W'(rd_cnt);
                        if (idx_q == '0) t1_q <= SUM_W'(rd_cnt);
                        idx_q <= idx_q + 1'b1;
                    end
                    ST_CHECK: begin
                        idx_q <= CODE_W'(1);
                        run_q <= t1_q;
                        if (total_q == t1_q) err_flag <= 1'b1;
                    end
                    ST_DIV_WAIT: begin
                        if (div_fin) begin
                            inl_valid <= 1'b1;
                            inl_code  <= idx_q;
                            inl_value <= new_inl;
                            if (new_abs > max_abs_inl) begin
                                max_abs_inl <= new_abs;
                                max_code    <= idx_q;
                            end
                            run_q <= run_q + SUM_W'(rd_cnt);
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    ST_IDLE, ST_DIV_GO, ST_DONE, ST_FAULT: begin
                    end
                endcase
            end
        end
    end

    assign done = (state == ST_DONE) || (state == ST_FAULT);
endmodule

// File: rtl/inl_estimator_chk.sv
module inl_estimator_chk #(
    parameter int CODE_W = 4,
    parameter int FRAC_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          inl_valid,
    input logic [CODE_W-1:0]             inl_code,
    input logic signed [CODE_W+FRAC_W:0] inl_value,
    input logic                          done,
    input logic                          err_flag,
    input logic                          sat_flag
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

    logic [CODE_W-1:0] prev_code;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_code <= '0;
        else if (start)     prev_code <= '0;
        else if (inl_valid) prev_code <= inl_code;
    end

    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) inl_valid |-> inl_code != '0); // R6
    AST_CODE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n) (inl_valid && inl_code != CODE_W'(1)) |-> inl_code == prev_code + 1'b1); // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (done && $past(done)) |-> !inl_valid); // R6
    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (inl_valid && inl_code == CODE_W'(1)) |-> inl_value == '0); // R7
    AST_LAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (inl_valid && inl_code == TOP_CODE) |-> inl_value == '0); // R7
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) err_flag |-> (done && !inl_valid)); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R10
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sat_flag && !start) |=> sat_flag); // R3
endmodule

bind inl_estimator inl_estimator_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .inl_valid (inl_valid),
    .inl_code  (inl_code),
    .inl_value (inl_value),
    .done      (done),
    .err_flag  (err_flag),
    .sat_flag  (sat_flag)
);

// File: tb/inl_estimator_test.sv
`timescale 1ns/1ps
module inl_estimator_test;
    localparam int CW = 4;
    localparam int NB = 16;
    localparam int CMAX = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic code_valid = 1'b0;
    logic [CW-1:0] code = '0;
    logic capture_end = 1'b0;
    logic inl_valid;
    logic [CW-1:0] inl_code;
    logic signed [12:0] inl_value;
    logic done, err_flag, sat_flag;
    logic [12:0] max_abs_inl;
    logic [CW-1:0] max_code;

    int checks = 0;
    int fails = 0;
    int hist [NB];

    always #2 clk = ~clk;

    inl_estimator uut (
        .clk(clk), .rst_n(rst_n), .start(start), .code_valid(code_valid),
        .code(code), .capture_end(capture_end), .inl_valid(inl_valid),
        .inl_code(inl_code), .inl_value(inl_value), .done(done),
        .err_flag(err_flag), .sat_flag(sat_flag), .max_abs_inl(max_abs_inl),
        .max_code(max_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_inl(input int k);
        longint t1, tk, tl, q;
        t1 = hist[0];
        tk = 0;
        tl = 0;
        for (int j = 0; j < k; j++) tk += hist[j];
        for (int j = 0; j < NB - 1; j++) tl += hist[j];
        q = ((tk - t1) * (NB - 2) * 256) / (tl - t1);
        return int'(q) - (k - 1) * 256;
    endfunction

    task automatic begin_run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int j = 0; j < NB; j++) hist[j] = 0;
    endtask

    task automatic hit(input int c);
        @(negedge clk); code = CW'(c); code_valid = 1'b1;
        @(negedge clk); code_valid = 1'b0; code = CW'(c + 5);
        if (hist[c] < CMAX) hist[c]++;
    endtask

    task automatic close_capture();
        @(negedge clk); capture_end = 1'b1;
        @(negedge clk); capture_end = 1'b0;
    endtask

    task automatic collect(input string tag);
        int k = 1;
        int mx = 0;
        int mc = 1;
        do begin
            @(negedge clk);
            if (inl_valid) begin
                int e = exp_inl(k);
                int a = e < 0 ? -e : e;
                chk(inl_code == CW'(k), {tag, " R6 code order"}, int'(inl_code), k);
                chk(int'(inl_value) == e, {tag, " R5 inl value"}, int'(inl_value), e);
                if (k == 1 || k == NB - 1)
                    chk(inl_value == 0, {tag, " R7 endpoint"}, int'(inl_value), 0);
                if (a > mx) begin mx = a; mc = k; end
                k++;
            end
        end while (!done);
        chk(k == NB, {tag, " R6 result count"}, k - 1, NB - 1);
        chk(int'(max_abs_inl) == mx, {tag, " R9 max magnitude"}, int'(max_abs_inl), mx);
        chk(int'(max_code) == mc, {tag, " R9 max code"}, int'(max_code), mc);
        chk(err_flag == 1'b0, {tag, " R8 no error"}, int'(err_flag), 0);
        repeat (6) @(negedge clk);
        chk(done == 1'b1, {tag, " R10 done held"}, int'(done), 1);
    endtask

    task automatic t_reset();
        chk(inl_valid == 0 && done == 0, "R1 reset valid/done", int'({inl_valid, done}), 0);
        chk(err_flag == 0 && sat_flag == 0, "R1 reset flags", int'({err_flag, sat_flag}), 0);
        chk(max_abs_inl == 0, "R1 reset max", int'(max_abs_inl), 0);
        repeat (5) @(negedge clk);
        chk(inl_valid == 0 && done == 0, "R1 idle quiet", int'({inl_valid, done}), 0);
    endtask

    task automatic t_uniform();
        begin_run();
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < NB; c++) hit(c);
        close_capture();
        collect("uniform R2 R4");
    endtask

    task automatic t_ramp();
        begin_run();
        for (int c = 0; c < NB; c++)
            for (int r = 0; r < ((c * 7) % 5) + 1 + (c == 6 ? 9 : 0); r++) hit(c);
        close_capture();
        collect("ramp R4 R5");
    endtask

    task automatic t_saturate();
        begin_run();
        for (int c = 0; c < NB; c++) begin hit(c); hit(c); end
        for (int r = 0; r < CMAX + 5; r++) hit(3);
        chk(sat_flag == 1'b1, "R3 saturation flag", int'(sat_flag), 1);
        close_capture();
        collect("saturate R3");
        begin_run();
        chk(sat_flag == 1'b0, "R2 start clears sat", int'(sat_flag), 0);
    endtask

    task automatic t_fault();
        int pulses = 0;
        begin_run();
        for (int r = 0; r < 3; r++) hit(0);
        for (int r = 0; r < 2; r++) hit(NB - 1);
        close_capture();
        do begin
            @(negedge clk);
            if (inl_valid) pulses++;
        end while (!done);
        repeat (4) @(negedge clk);
        chk(err_flag == 1'b1, "R8 error flag", int'(err_flag), 1);
        chk(pulses == 0 && inl_valid == 0, "R8 no results", pulses, 0);
        chk(done == 1'b1, "R8 R10 done on fault", int'(done), 1);
    endtask

    task automatic t_restart();
        begin_run();
        for (int c = 0; c < NB; c++) for (int r = 0; r <= c % 4; r++) hit(c);
        close_capture();
        repeat (60) @(negedge clk);
        begin_run();
        chk(done == 1'b0 && err_flag == 1'b0, "R2 restart clears", int'({done, err_flag}), 0);
        for (int c = 0; c < NB; c++) for (int r = 0; r < 2 + (c == 9 ? 3 : 0); r++) hit(c);
        close_capture();
        collect("restart R2");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_uniform();
        t_ramp();
        t_fault();
        t_saturate();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule